// File: doc/BRIEF.md
# SPI 24-bit Command Frame Receiver

This block is the serial front end of a small register-controlled device. A host talks to it over a four-wire SPI link. Each transaction is one 24-bit word, sent most significant bit first. The word carries a 4-bit operation code, a 4-bit register address, six ignored bits and a 10-bit value. The SPI pins are asynchronous to the block's own clock. They pass through a synchronizer and are oversampled, so every decision is taken on the system clock. Input bits are taken on rising serial-clock edges, in both SPI mode 0 and SPI mode 3. A word counts as complete only when chip select goes high again after exactly 24 rising edges.

A complete word, unless it is a no-operation, is offered to the command processor on a valid/ready output. The block raises `frm_valid` and holds the fields stable until the processor raises `frm_ready` in the same cycle. That cycle is the handshake, and `frm_valid` drops on the next edge. The receiver has no queue. A word that completes while an earlier one is still waiting for its handshake is lost.

The serial output echoes the previous 24 bits that came in, so that devices can be chained. It also carries register readback. When the processor accepts a readback operation while chip select is high, it drives the register value on `rb_data` in that cycle. That value replaces the low 16 bits of the shift register, and the next word clocks it out. The output pin is open drain. It is modelled as a data bit plus an enable that is asserted only when the pin pulls low.

Top module: `spi24_frame_rx`

## Requirements
- R1: While reset is active and just after it, `frm_valid` and `sdo_oe` are low. The shift register holds all zeros, so the first word after reset shifts out 24 zero bits.
- R2: A word is taken MSB first, one bit per rising serial-clock edge. Bits 23:20 go to `frm_cmd`, bits 19:16 to `frm_addr` and bits 9:0 to `frm_data`. Bits 15:10 affect no output field.
- R3: `frm_valid` never rises while chip select is low, even after 24 edges. It rises within a few system cycles after chip select goes high.
- R4: A word with fewer or more than 24 rising edges before chip select rises produces no `frm_valid`.
- R5: A complete word whose bits 23:20 equal 0 is a no-operation and produces no `frm_valid`.
- R6: While `frm_valid` is high and `frm_ready` is low, the fields stay stable. A word that completes during this wait is discarded. After the handshake cycle, `frm_valid` is low.
- R7: `sdo_oe` is high only while `sdo_bit` is 0. Within `SYNC_STAGES`+2 cycles after chip select goes high, `sdo_oe` is low.
- R8: During a word, `sdo_bit` presents the bits held in the shift register MSB first. These are the last 24 bits received, ahead of each rising edge, in mode 0 and in mode 3.
- R9: When a word with bits 23:20 equal to 9 or 10 is handshaken while chip select is high, the next word's output is changed. Its bits 15:10 shift out as 0 and its bits 9:0 shift out the `rb_data` value from the handshake cycle. Bits 23:16 still echo the readback word.
- R10: A readback handshake that happens while chip select is low leaves the shift register untouched. The output keeps echoing the received bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock, asynchronous |
| spi_cs_n | input | 1 | Active-low chip select, asynchronous |
| spi_mosi | input | 1 | Serial data in |
| sdo_bit | output | 1 | Serial output data value |
| sdo_oe | output | 1 | Open-drain pull-down enable |
| frm_valid | output | 1 | Decoded word is offered |
| frm_ready | input | 1 | Command processor accepts the word |
| frm_cmd | output | CMD_W | Operation code |
| frm_addr | output | ADDR_W | Register address |
| frm_data | output | DATA_W | Data value |
| rb_data | input | DATA_W | Readback value, sampled at a readback handshake |

## Verification
The hardest situation to reach from the ports is a readback handshake that lands while the next word is already being shifted in. That is the only path on which the substitution must be suppressed. The stimulus holds `frm_ready` low after a readback word and starts a new word. It then pulses the handshake after a few bits, while chip select is low. The serial output of the rest of that word and of the following word is compared against a bit-level model in which no substitution took place.

// File: rtl/spi24_pkg.sv
package spi24_pkg;

  // Edge and level events derived from the synchronized serial pins
  typedef struct packed {
    logic sck_rise;
    logic sck_fall;
    logic cs_fall;
    logic cs_rise;
    logic cs_active;
    logic mosi;
  } spi24_evt_t;

endpackage

// File: rtl/spi24_sync.sv
module spi24_sync
  import spi24_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       mosi,
  output spi24_evt_t evt
);

  localparam int unsigned NSIG = 3;
  // reset level per signal, order {mosi, cs_n, sck}
  localparam logic [NSIG-1:0] RST_LVL = 3'b010;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] synced;
  logic            sck_d;
  logic            cs_d;

  assign raw = {mosi, cs_n, sck};

  for (genvar g = 0; g < NSIG; g++) begin : g_chain
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_LVL[g]}};
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= synced[0];
      cs_d  <= synced[1];
    end
  end

  always_comb begin
    evt.cs_active = ~synced[1];
    evt.sck_rise  =  synced[0] & ~sck_d & ~synced[1];
    evt.sck_fall  = ~synced[0] &  sck_d & ~synced[1];
    evt.cs_fall   = ~synced[1] &  cs_d;
    evt.cs_rise   =  synced[1] & ~cs_d;
    evt.mosi      =  synced[2];
  end

endmodule

// File: rtl/spi24_shifter.sv
module spi24_shifter #(
  parameter int unsigned CMD_W  = 4,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned PAD_W  = 6,
  parameter int unsigned DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              cs_fall,
  input  logic              mosi,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_val,
  output logic [CMD_W-1:0]  cmd_f,
  output logic [ADDR_W-1:0] addr_f,
  output logic [DATA_W-1:0] data_f,
  output logic              sdo_q
);

  localparam int unsigned NBITS = CMD_W + ADDR_W + PAD_W + DATA_W;
  localparam int unsigned LOW_W = PAD_W + DATA_W;

  logic [NBITS-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
    end else if (sck_rise) begin
      shreg <= {shreg[NBITS-2:0], mosi};
    end else if (load_en) begin
      shreg[LOW_W-1:0] <= LOW_W'(load_val);
    end
  end

  // output bit advances on the launch edge: chip-select fall or clock fall
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  sdo_q <= 1'b1;
    else if (cs_fall | sck_fall) sdo_q <= shreg[NBITS-1];
  end

  assign cmd_f  = shreg[NBITS-1 -: CMD_W];
  assign addr_f = shreg[NBITS-CMD_W-1 -: ADDR_W];
  assign data_f = shreg[DATA_W-1:0];

endmodule

// File: rtl/spi24_frame_ctl.sv
module spi24_frame_ctl #(
  parameter int unsigned CMD_W    = 4,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 10,
  parameter int unsigned NBITS    = 24,
  parameter int unsigned NOP_OP   = 0,
  parameter int unsigned RB_OP_A  = 9,
  parameter int unsigned RB_OP_B  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              cs_active,
  input  logic [CMD_W-1:0]  cmd_f,
  input  logic [ADDR_W-1:0] addr_f,
  input  logic [DATA_W-1:0] data_f,
  input  logic              frm_ready,
  output logic              frm_valid,
  output logic [CMD_W-1:0]  frm_cmd,
  output logic [ADDR_W-1:0] frm_addr,
  output logic [DATA_W-1:0] frm_data,
  output logic              rb_load
);

  localparam int unsigned CNT_W = $clog2(NBITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(NBITS);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(NBITS + 1);

  logic [CNT_W-1:0] bit_cnt;
  logic             frame_ok;
  logic             take;
  logic             is_rb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             bit_cnt <= '0;
    else if (cs_fall)                       bit_cnt <= '0;
    else if (sck_rise && bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + 1'b1;
  end

  assign frame_ok = cs_rise && (bit_cnt == CNT_FULL) && (cmd_f != CMD_W'(NOP_OP));
  assign take     = frame_ok && !frm_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_valid <= 1'b0;
      frm_cmd   <= '0;
      frm_addr  <= '0;
      frm_data  <= '0;
    end else begin
      if (frm_valid && frm_ready) frm_valid <= 1'b0;
      if (take) begin
        frm_valid <= 1'b1;
        frm_cmd   <= cmd_f;
        frm_addr  <= addr_f;
        frm_data  <= data_f;
      end
    end
  end

  assign is_rb   = (frm_cmd == CMD_W'(RB_OP_A)) || (frm_cmd == CMD_W'(RB_OP_B));
  assign rb_load = frm_valid && frm_ready && is_rb && !cs_active;

endmodule

// File: rtl/spi24_frame_rx.sv
module spi24_frame_rx
  import spi24_pkg::*;
#(
  parameter int unsigned CMD_W       = 4,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned PAD_W       = 6,
  parameter int unsigned DATA_W      = 10,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned NOP_OP      = 0,
  parameter int unsigned RB_OP_A     = 9,
  parameter int unsigned RB_OP_B     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              sdo_bit,
  output logic              sdo_oe,
  output logic              frm_valid,
  input  logic              frm_ready,
  output logic [CMD_W-1:0]  frm_cmd,
  output logic [ADDR_W-1:0] frm_addr,
  output logic [DATA_W-1:0] frm_data,
  input  logic [DATA_W-1:0] rb_data
);

  localparam int unsigned NBITS = CMD_W + ADDR_W + PAD_W + DATA_W;

  spi24_evt_t        evt;
  logic [CMD_W-1:0]  cmd_f;
  logic [ADDR_W-1:0] addr_f;
  logic [DATA_W-1:0] data_f;
  logic              rb_load;
  logic              sdo_q;

  spi24_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .sck   (spi_sck),
    .cs_n  (spi_cs_n),
    .mosi  (spi_mosi),
    .evt   (evt)
  );

  spi24_shifter #(
    .CMD_W(CMD_W), .ADDR_W(ADDR_W), .PAD_W(PAD_W), .DATA_W(DATA_W)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_rise (evt.sck_rise),
    .sck_fall (evt.sck_fall),
    .cs_fall  (evt.cs_fall),
    .mosi     (evt.mosi),
    .load_en  (rb_load),
    .load_val (rb_data),
    .cmd_f    (cmd_f),
    .addr_f   (addr_f),
    .data_f   (data_f),
    .sdo_q    (sdo_q)
  );

  spi24_frame_ctl #(
    .CMD_W(CMD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBITS(NBITS),
    .NOP_OP(NOP_OP), .RB_OP_A(RB_OP_A), .RB_OP_B(RB_OP_B)
  ) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck_rise  (evt.sck_rise),
    .cs_fall   (evt.cs_fall),
    .cs_rise   (evt.cs_rise),
    .cs_active (evt.cs_active),
    .cmd_f     (cmd_f),
    .addr_f    (addr_f),
    .data_f    (data_f),
    .frm_ready (frm_ready),
    .frm_valid (frm_valid),
    .frm_cmd   (frm_cmd),
    .frm_addr  (frm_addr),
    .frm_data  (frm_data),
    .rb_load   (rb_load)
  );

  assign sdo_bit = sdo_q;
  assign sdo_oe  = evt.cs_active & ~sdo_q;

endmodule

// File: rtl/spi24_frame_rx_chk.sv
module spi24_frame_rx_chk #(
  parameter int unsigned CMD_W       = 4,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 10,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned NOP_OP      = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_cs_n,
  input logic              sdo_bit,
  input logic              sdo_oe,
  input logic              frm_valid,
  input logic              frm_ready,
  input logic [CMD_W-1:0]  frm_cmd,
  input logic [ADDR_W-1:0] frm_addr,
  input logic [DATA_W-1:0] frm_data
);

  localparam int unsigned LIM   = SYNC_STAGES + 2;
  localparam int unsigned CNT_W = $clog2(LIM + 2);

  logic [CNT_W-1:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       idle_cnt <= '0;
    else if (!spi_cs_n)               idle_cnt <= '0;
    else if (idle_cnt != CNT_W'(LIM)) idle_cnt <= idle_cnt + 1'b1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!frm_valid && !sdo_oe));

  a_r7_drive_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> !sdo_bit);

  a_r7_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_cnt == CNT_W'(LIM)) |-> !sdo_oe);

  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !frm_ready) |=>
      (frm_valid && $stable(frm_cmd) && $stable(frm_addr) && $stable(frm_data)));

  a_r6_clear_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_ready) |=> !frm_valid);

  a_r5_no_nop_out: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> (frm_cmd != CMD_W'(NOP_OP)));

  a_r3_rise_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frm_valid) |-> $past(spi_cs_n));

endmodule

bind spi24_frame_rx spi24_frame_rx_chk #(
  .CMD_W(CMD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .SYNC_STAGES(SYNC_STAGES), .NOP_OP(NOP_OP)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .spi_cs_n  (spi_cs_n),
  .sdo_bit   (sdo_bit),
  .sdo_oe    (sdo_oe),
  .frm_valid (frm_valid),
  .frm_ready (frm_ready),
  .frm_cmd   (frm_cmd),
  .frm_addr  (frm_addr),
  .frm_data  (frm_data)
);

// File: tb/test_spi24_frame_rx.sv
module test_spi24_frame_rx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sck = 1'b0;
  logic       spi_cs_n = 1'b1;
  logic       spi_mosi = 1'b0;
  logic       sdo_bit;
  logic       sdo_oe;
  logic       frm_valid;
  logic       frm_ready = 1'b0;
  logic [3:0] frm_cmd;
  logic [3:0] frm_addr;
  logic [9:0] frm_data;
  logic [9:0] rb_data = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [23:0] mdl = '0;

  always #2 clk = ~clk;

  spi24_frame_rx i_spi24_frame_rx (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .sdo_bit(sdo_bit), .sdo_oe(sdo_oe),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_cmd(frm_cmd),
    .frm_addr(frm_addr), .frm_data(frm_data), .rb_data(rb_data)
  );

  // {mode3, nbits, word, expect_valid, rb_value}
  localparam logic [40:0] VECS [9] = '{
    {1'b0, 5'd24, 4'hB, 4'h1, 6'h3F, 10'h2A5, 1'b1, 10'h000},
    {1'b1, 5'd24, 4'h3, 4'h0, 6'h00, 10'h3FF, 1'b1, 10'h000},
    {1'b0, 5'd24, 4'h0, 4'h5, 6'h15, 10'h155, 1'b0, 10'h000},
    {1'b1, 5'd23, 4'hE, 4'h1, 6'h00, 10'h0AA, 1'b0, 10'h000},
    {1'b0, 5'd25, 4'h6, 4'h0, 6'h00, 10'h001, 1'b0, 10'h000},
    {1'b1, 5'd24, 4'h9, 4'h1, 6'h2A, 10'h000, 1'b1, 10'h155},
    {1'b0, 5'd24, 4'hE, 4'h0, 6'h00, 10'h000, 1'b1, 10'h000},
    {1'b1, 5'd24, 4'hA, 4'h0, 6'h3F, 10'h3FF, 1'b1, 10'h0F0},
    {1'b0, 5'd24, 4'h1, 4'h1, 6'h00, 10'h200, 1'b1, 10'h000}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic accept(input logic [9:0] rb);
    @(negedge clk);
    frm_ready = 1'b1;
    rb_data   = rb;
    @(negedge clk);
    frm_ready = 1'b0;
  endtask

  task automatic send_frame(input bit m3, input int nb, input logic [23:0] w,
                            input bit chk_idle, input int hs_at, input logic [9:0] hs_rb);
    int mism = 0;
    int first_bad = -1;
    logic b;
    spi_sck = m3;
    wclk(8);
    spi_cs_n = 1'b0;
    wclk(8);
    for (int i = 0; i < nb; i++) begin
      if (i == hs_at) accept(hs_rb);
      b = (i < 24) ? w[23-i] : 1'b0;
      if (m3) spi_sck = 1'b0;
      spi_mosi = b;
      wclk(8);
      if (sdo_bit !== mdl[23] || sdo_oe !== ~mdl[23]) begin
        mism++;
        if (first_bad < 0) first_bad = i;
      end
      mdl = {mdl[22:0], b};
      spi_sck = 1'b1;
      wclk(8);
      if (!m3) spi_sck = 1'b0;
    end
    wclk(8);
    // R8 R9 R10: echo of held bits, both modes
    chk(mism == 0, "R8/R9/R10 serial output mismatches, first bad bit index", first_bad, -1);
    if (chk_idle) chk(frm_valid == 1'b0, "R3 valid while chip select low", frm_valid, 0);
    spi_cs_n = 1'b1;
    wclk(12);
    chk(sdo_oe == 1'b0, "R7 output released with chip select high", sdo_oe, 0);
  endtask

  initial begin
    wclk(5);
    // R1: reset state
    chk(frm_valid == 1'b0, "R1 valid in reset", frm_valid, 0);
    chk(sdo_oe == 1'b0, "R1 oe in reset", sdo_oe, 0);
    rst_n = 1'b1;
    wclk(4);
    chk(frm_valid == 1'b0 && sdo_oe == 1'b0, "R1 idle after reset", {frm_valid, sdo_oe}, 0);

    foreach (VECS[k]) begin
      logic [23:0] w;
      w = VECS[k][34:11];
      send_frame(VECS[k][40], int'(VECS[k][39:35]), w, 1'b1, -1, '0);
      // R3 R4 R5: presence of the decoded word
      chk(frm_valid == VECS[k][10], "R3/R4/R5 valid after chip select rise", frm_valid, VECS[k][10]);
      if (VECS[k][10]) begin
        chk(frm_cmd == w[23:20], "R2 command field", frm_cmd, w[23:20]);
        chk(frm_addr == w[19:16], "R2 address field", frm_addr, w[19:16]);
        chk(frm_data == w[9:0], "R2 data field", frm_data, w[9:0]);
        accept(VECS[k][9:0]);
        if (w[23:20] == 4'd9 || w[23:20] == 4'd10) mdl[15:0] = {6'b0, VECS[k][9:0]};
        wclk(2);
        chk(frm_valid == 1'b0, "R6 valid cleared after handshake", frm_valid, 0);
      end
    end

    // R6: second word during a pending one is dropped
    send_frame(1'b0, 24, {4'h2, 4'h3, 6'h00, 10'h111}, 1'b1, -1, '0);
    send_frame(1'b1, 24, {4'h4, 4'h7, 6'h00, 10'h222}, 1'b0, -1, '0);
    chk(frm_valid == 1'b1, "R6 valid held", frm_valid, 1);
    chk(frm_cmd == 4'h2 && frm_addr == 4'h3 && frm_data == 10'h111,
        "R6 fields held from first word", {frm_cmd, frm_addr, frm_data}, {4'h2, 4'h3, 10'h111});
    accept('0);
    wclk(4);
    chk(frm_valid == 1'b0, "R6 dropped word never offered", frm_valid, 0);

    // R10: readback accepted while the next word is in flight
    send_frame(1'b0, 24, {4'hA, 4'h2, 6'h00, 10'h000}, 1'b1, -1, '0);
    send_frame(1'b0, 24, {4'h5, 4'h6, 6'h3F, 10'h0C3}, 1'b0, 4, 10'h3C3);
    chk(frm_valid == 1'b1 && frm_cmd == 4'h5, "R10 in-flight word offered", {frm_valid, frm_cmd}, {1'b1, 4'h5});
    accept('0);
    send_frame(1'b1, 24, {4'h7, 4'h0, 6'h00, 10'h000}, 1'b1, -1, '0);
    accept('0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule